// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block collects seven level-sensitive event lines into a single summary interrupt. Each input is watched for a rising edge; a rising edge latches a bit in a cause register. A separate enable register selects which latched causes may drive the summary line. Both registers are reached over a small register bus with a write strobe, a byte address, 32-bit write data and combinational read data. The summary output is high whenever any cause bit is set while its enable bit is also set.

The cause register is plain read/write. A bus write stores the written value, so software can raise a cause bit by writing a 1 as well as clear it by writing a 0. A hardware edge that arrives in the same cycle as a cause write wins for its own bit, so no event is lost during a clear. The block also reports the index of the most significant pending source, with a valid flag.

The bus has no back-pressure. A write completes in the cycle its strobe is sampled, and read data follows the address combinationally. No data stream enters or leaves the block, so every pin is a plain control or status signal.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset the cause register and the enable register read 0, `irq_o` is 0, `hp_valid_o` is 0 and `hp_idx_o` is 0.
- R2: A 0-to-1 change on `evt_i[k]` sets cause bit k at the next rising clock edge. A line held high sets the bit only once. After software clears the bit, it stays clear while the line stays high.
- R3: A write to byte address 0x50 loads bits 6:0 of the write data into the cause register, which sets or clears each bit. The new value is readable after that edge.
- R4: A write to byte address 0x54 loads bits 6:0 of the write data into the enable register. An enable bit of 1 lets that source drive the summary line, and 0 blocks it. The value reads back at 0x54.
- R5: `irq_o` is 1 exactly when the bitwise AND of cause and enable is nonzero.
- R6: When a rising edge on `evt_i[k]` and a cause write with data bit k = 0 fall in the same cycle, cause bit k ends up 1. The other bits take the written value.
- R7: `hp_valid_o` is 1 exactly when the pending set (cause AND enable) is nonzero. `hp_idx_o` then gives the highest set bit position of that set, and it is 0 when nothing is pending.
- R8: Bits 31:7 of both registers read as 0. Any other address reads 0. A write to any other address changes neither register.
- R9: Writing 0 to address 0x54 and then 0 to address 0x50 leaves both registers at 0 and `irq_o` at 0, even after sources had been pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Event lines, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address for read and write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Summary interrupt |
| hp_valid_o | output | 1 | High when any source is pending |
| hp_idx_o | output | 3 | Index of the most significant pending source |

## Verification
Random toggling of the event lines, mixed with random writes to the cause address, the enable address and unmapped addresses, is compared every cycle against a bench model. This separates a correct merge of edge setting with write data from one that lets either side win. Directed sequences cover specific cases. A line held high across a software clear tells edge detection from level detection. An edge that coincides with a clearing write checks the priority of hardware over software. Writes of all ones to the upper data bits and to stray addresses expose decode or width leaks. The enable-then-cause zeroing sequence is also applied after several sources are pending.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int unsigned SRC_CNT   = 7;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 32;
  localparam logic [7:0]  CAUSE_OFS = 8'h50;
  localparam logic [7:0]  ENA_OFS   = 8'h54;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CAUSE = 2'd1,
    SEL_ENA   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end

  // R2: an edge pulse never repeats on the following cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
#(
  parameter int unsigned N      = SRC_CNT,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter logic [AW-1:0] C_OFS = AW'(CAUSE_OFS),
  parameter logic [AW-1:0] E_OFS = AW'(ENA_OFS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  rise_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [N-1:0]  cause_o,
  output logic [N-1:0]  ena_o
);
  localparam int unsigned PAD_W = DW - N;

  reg_sel_e     sel;
  logic [N-1:0] cause_q, cause_d;
  logic [N-1:0] ena_q,   ena_d;

  always_comb begin
    if (addr_i == C_OFS)      sel = SEL_CAUSE;
    else if (addr_i == E_OFS) sel = SEL_ENA;
    else                      sel = SEL_NONE;
  end

  // Software write first, then hardware edges OR in on top (edges win).
  always_comb begin
    cause_d = cause_q;
    ena_d   = ena_q;
    if (wr_i && sel == SEL_CAUSE) cause_d = wdata_i;
    if (wr_i && sel == SEL_ENA)   ena_d   = wdata_i;
    cause_d = cause_d | rise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      ena_q   <= '0;
    end else begin
      cause_q <= cause_d;
      ena_q   <= ena_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rdata_o = {{PAD_W{1'b0}}, cause_q};
      SEL_ENA:   rdata_o = {{PAD_W{1'b0}}, ena_q};
      default:   rdata_o = '0;
    endcase
  end

  assign cause_o = cause_q;
  assign ena_o   = ena_q;

  // R2: every edge pulse lands in the cause register
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i != '0) |=> ((cause_q & $past(rise_i)) == $past(rise_i)));
  // R2: without a cause write no bit falls
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == C_OFS) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  // R3: a cause write with no edges takes the written value
  a_r3_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == C_OFS && rise_i == '0) |=> (cause_q == $past(wdata_i)));
  // R4: an enable write takes the written value
  a_r4_ena_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == E_OFS) |=> (ena_q == $past(wdata_i)));
  // R8: the enable register does not move without its own write
  a_r8_ena_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == E_OFS) |=> $stable(ena_q));
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
  parameter int unsigned N  = 7,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // Ascending scan: the last set bit seen is the most significant one.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) idx_o = IW'(i);
    end
  end

  assign valid_o = |pend_i;

  // R7: the reported index is pending and nothing above it is
  always_comb begin
    if (valid_o) begin
      a_r7_idx_set: assert (((pend_i >> idx_o) & N'(1)) == N'(1));
      a_r7_idx_top: assert ((pend_i >> idx_o) == N'(1));
    end
  end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_CNT,
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned IW      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               bus_wr_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               irq_o,
  output logic               hp_valid_o,
  output logic [IW-1:0]      hp_idx_o
);
  logic [NUM_SRC-1:0] rise, cause, ena, pend;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata_i[DW-1:NUM_SRC];

  irqagg_edge #(.N(NUM_SRC)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(rise));

  irqagg_regs #(.N(NUM_SRC), .AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i[NUM_SRC-1:0]),
    .rdata_o(bus_rdata_o), .cause_o(cause), .ena_o(ena));

  assign pend  = cause & ena;
  assign irq_o = |pend;

  irqagg_prio #(.N(NUM_SRC), .IW(IW)) prio_i (
    .pend_i(pend), .valid_o(hp_valid_o), .idx_o(hp_idx_o));

  // R5/R7: summary line and valid flag come from separate logic and must agree
  a_r5_irq_valid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == hp_valid_o);
  // R6: an edge during a clearing cause write still leaves its bit set
  a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && rise != '0) |=> ((cause & $past(rise)) == $past(rise)));
  // R1: no pending index while nothing is pending
  a_r1_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_valid_o |-> hp_idx_o == '0);
endmodule

// File: tb/irq_cause_agg_tb_top.sv
`timescale 1ns/1ps
module irq_cause_agg_tb_top;
  localparam logic [7:0] A_CAUSE = 8'h50;
  localparam logic [7:0] A_ENA   = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, hv;
  logic [2:0]  hidx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0] m_cause = '0, m_ena = '0, m_prev = '0;

  always #10 clk = ~clk;

  irq_cause_agg dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .hp_valid_o(hv), .hp_idx_o(hidx));

  function automatic logic [2:0] exp_idx(logic [6:0] p);
    logic [2:0] r = '0;
    for (int i = 0; i < 7; i++) if (p[i]) r = 3'(i);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [6:0] rise;
    rise   = evt & ~m_prev;
    m_prev = evt;
    if (wr && addr == A_CAUSE) m_cause = wdata[6:0];
    if (wr && addr == A_ENA)   m_ena   = wdata[6:0];
    m_cause = m_cause | rise;
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    logic [6:0] p;
    p = m_cause & m_ena;
    chk({tag, " R5 irq"}, 32'(irq), 32'(p != 0));
    chk({tag, " R7 valid"}, 32'(hv), 32'(p != 0));
    chk({tag, " R7 idx"}, 32'(hidx), 32'(exp_idx(p)));
    rd(A_CAUSE, d); chk({tag, " R3 cause"}, d, {25'b0, m_cause});
    rd(A_ENA, d);   chk({tag, " R4 ena"}, d, {25'b0, m_ena});
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(A_CAUSE, d); chk("R1 cause", d, 32'h0);
    rd(A_ENA, d);   chk("R1 ena", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 valid", 32'(hv), 32'h0);
    chk("R1 idx", 32'(hidx), 32'h0);

    // R2: edge sets once; held level does not re-set after clear
    evt = 7'h08; tick();
    rd(A_CAUSE, d); chk("R2 edge set", d, 32'h08);
    bus_write(A_CAUSE, 32'h0); tick();
    rd(A_CAUSE, d); chk("R2 held level no reset", d, 32'h00);
    evt = 7'h00; tick();

    // R3: write can set bits
    bus_write(A_CAUSE, 32'h25);
    rd(A_CAUSE, d); chk("R3 write set", d, 32'h25);
    // R4 + R5 + R7: enable picks pending sources
    bus_write(A_ENA, 32'h21);
    chk("R5 irq enabled", 32'(irq), 32'h1);
    chk("R7 idx top", 32'(hidx), 32'd5);
    bus_write(A_ENA, 32'h04);
    chk("R7 idx single", 32'(hidx), 32'd2);
    bus_write(A_ENA, 32'h02);
    chk("R5 masked off", 32'(irq), 32'h0);
    chk("R7 none valid", 32'(hv), 32'h0);

    // R6: edge same cycle as clearing write
    evt = 7'h20; wr = 1'b1; addr = A_CAUSE; wdata = 32'h0; tick();
    rd(A_CAUSE, d); chk("R6 edge beats clear", d, 32'h20);
    evt = 7'h00; tick();

    // R8: upper bits and stray addresses
    bus_write(A_ENA, 32'hFFFF_FF80);
    rd(A_ENA, d); chk("R8 ena upper ignored", d, 32'h0);
    bus_write(8'h58, 32'hFFFF_FFFF);
    rd(A_CAUSE, d); chk("R8 stray write cause", d, 32'h20);
    rd(A_ENA, d);   chk("R8 stray write ena", d, 32'h0);
    rd(8'h30, d);   chk("R8 stray read", d, 32'h0);
    bus_write(A_CAUSE, 32'hFFFF_FFFF);
    rd(A_CAUSE, d); chk("R8 cause upper zero", d, 32'h7F);

    // R9: enable then cause zeroing
    bus_write(A_ENA, 32'h7F);
    chk("R9 pending before", 32'(irq), 32'h1);
    bus_write(A_ENA, 32'h0);
    bus_write(A_CAUSE, 32'h0);
    rd(A_CAUSE, d); chk("R9 cause zero", d, 32'h0);
    rd(A_ENA, d);   chk("R9 ena zero", d, 32'h0);
    chk("R9 irq low", 32'(irq), 32'h0);

    // Random phase against the model
    for (int n = 0; n < 800; n++) begin
      evt = evt ^ 7'($urandom & $urandom & $urandom);
      wr  = ($urandom % 3) == 0;
      case ($urandom % 5)
        0, 1: addr = A_CAUSE;
        2, 3: addr = A_ENA;
        default: addr = 8'($urandom);
      endcase
      wdata = (($urandom % 4) == 0) ? 32'h0 : $urandom;
      tick();
      check_all("RND R2 R6");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule